// File: doc/BRIEF.md
# Chip-select-timed serial ADC sample reader

This block is the master side of a serial link to a 12-bit ADC whose sampling is paced by its chip-select line. A one-cycle `start` request begins a read. The block first holds chip select high for a programmed acquisition window, so the converter can track its input. It then drops chip select and waits out a programmed conversion window with the serial clock idle. Only after that does it issue twelve clock pulses and shift in the sample from `miso`, most significant bit first. The assembled word appears on `result`, and `done` pulses for one cycle.

The serial clock can be shared with other slaves. It idles low, and this block only drives it while its own read is in progress. After a read, chip select stays low. The next read raises it again to open a new acquisition. Every phase length is a count of system-clock cycles. The defaults (45 acquisition, 119 conversion, 2-cycle clock halves) fit a 32 MHz system clock.

The result is a plain held register with no back-pressure. It changes only on the `done` cycle and keeps its value until the next completion, so a consumer may capture it on `done` or at any later time before the next read ends. A `start` seen while a read is in progress is dropped. A `start` in the same cycle as `done` is accepted.

Top module: `adc_sample_reader`

## Requirements
- R1: After reset, `cs_n` is 0, `sclk` is 0, `done` is 0, `busy` is 0 and `result` is 0.
- R2: A `start` sampled while idle drives `cs_n` to 1 on the next clock edge, and `cs_n` stays 1 for exactly ACQ_CYC cycles.
- R3: When `cs_n` falls, `sclk` stays 0 for exactly CONV_CYC cycles before its first rising edge. `sclk` is never 1 while `cs_n` is 1.
- R4: Each read produces exactly 12 `sclk` pulses. Each pulse is high for HALF_HI cycles, and the low gap between pulses is HALF_LO cycles.
- R5: `result[11]` holds the bit read during the first pulse, and `result[0]` holds the bit read during the twelfth.
- R6: `miso` is sampled while `sclk` is 1, in the last system cycle of each high half. The value of `miso` while `sclk` is 0 has no effect on `result`.
- R7: After the twelfth pulse, `cs_n` stays 0 and `sclk` stays 0 until the next `start`.
- R8: `done` is 1 for exactly one cycle per read. `result` changes only in the cycle where `done` is 1.
- R9: `start` is ignored while `busy` is 1. `cs_n` does not rise again, and the read in progress completes with the correct word.
- R10: A `start` applied in the cycle where `done` is 1 is accepted. `cs_n` is 1 in the next cycle, and the second read completes normally.
- R11: `busy` is 1 from the cycle after an accepted `start` until the cycle where `done` is 1, and 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion read |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 12 | Last completed sample, MSB first as received |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low ADC chip select |
| miso | input | 1 | Serial data from the ADC |

## Verification
Two functions can fall in the same cycle: finishing a read and accepting a new one. The bench raises `start` in exactly the cycle where it sees `done`. It then requires `cs_n` to be high one cycle later, requires the first result to still be on `result`, and requires the chained read to return its own word with correct phase lengths. A hostile slave mode drives the inverted bit whenever `sclk` is low, so only sampling during the high half gives the right word. Requests sent during acquisition and during shifting must leave the phase timing and the result unchanged.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_HIGH,
    ST_LOW
  } rd_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic             last_bit,
  output logic [NBITS-1:0] next_word
);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [NBITS-1:0] sh;
  logic [BW-1:0]    bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (clear) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (shift_en) begin
      sh   <= next_word;
      bcnt <= bcnt + 1'b1;
    end
  end

  assign next_word = {sh[NBITS-2:0], din};
  assign last_bit  = (bcnt == BW'(NBITS - 1));
endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader
  import adc_rd_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter int ACQ_CYC  = 45,
  parameter int CONV_CYC = 119,
  parameter int HALF_HI  = 2,
  parameter int HALF_LO  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] result,
  output logic             sclk,
  output logic             cs_n,
  input  logic             miso
);
  localparam int MAXC = max_of4(ACQ_CYC, CONV_CYC, HALF_HI, HALF_LO);
  localparam int CW   = $clog2(MAXC + 1);

  rd_state_e        st, st_nxt;
  logic             tmr_load, tmr_exp;
  logic [CW-1:0]    tmr_val;
  logic             sh_clear, sh_en, sh_last;
  logic [NBITS-1:0] sh_word;
  logic             cs_nxt, sclk_nxt, fin;

  adc_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  adc_bit_shifter #(.NBITS(NBITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sh_clear),
    .shift_en  (sh_en),
    .din       (miso),
    .last_bit  (sh_last),
    .next_word (sh_word)
  );

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_clear = 1'b0;
    sh_en    = 1'b0;
    cs_nxt   = cs_n;
    sclk_nxt = sclk;
    fin      = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        st_nxt   = ST_ACQ;
        tmr_load = 1'b1;
        tmr_val  = CW'(ACQ_CYC - 1);
        cs_nxt   = 1'b1;
        sh_clear = 1'b1;
      end
      ST_ACQ: if (tmr_exp) begin
        st_nxt   = ST_CONV;
        tmr_load = 1'b1;
        tmr_val  = CW'(CONV_CYC - 1);
        cs_nxt   = 1'b0;
      end
      ST_CONV: if (tmr_exp) begin
        st_nxt   = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_HI - 1);
        sclk_nxt = 1'b1;
      end
      ST_HIGH: if (tmr_exp) begin
        sh_en    = 1'b1;
        sclk_nxt = 1'b0;
        if (sh_last) begin
          st_nxt = ST_IDLE;
          fin    = 1'b1;
        end else begin
          st_nxt   = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = CW'(HALF_LO - 1);
        end
      end
      ST_LOW: if (tmr_exp) begin
        st_nxt   = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_HI - 1);
        sclk_nxt = 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cs_n   <= 1'b0;
      sclk   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      st   <= st_nxt;
      cs_n <= cs_nxt;
      sclk <= sclk_nxt;
      done <= fin;
      if (fin) result <= sh_word;
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/adc_sample_reader_chk.sv
module adc_sample_reader_chk #(
  parameter int NBITS   = 12,
  parameter int ACQ_CYC = 45
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [NBITS-1:0] result,
  input logic             sclk,
  input logic             cs_n
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run <= '0;
    else if (cs_n) hi_run <= hi_run + 1'b1;
    else           hi_run <= '0;
  end

  // R2
  acq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(start));

  // R2
  acq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_run == 16'(ACQ_CYC)));

  // R3
  no_clk_in_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R7
  sclk_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R9
  no_reacq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n) |=> !cs_n);

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind adc_sample_reader adc_sample_reader_chk #(
  .NBITS   (NBITS),
  .ACQ_CYC (ACQ_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .sclk   (sclk),
  .cs_n   (cs_n)
);

// File: tb/adc_sample_reader_test.sv
module adc_sample_reader_test;
  localparam int ACQ  = 45;
  localparam int CONV = 119;
  localparam int HH   = 2;
  localparam int HL   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, sclk, cs_n, miso;
  logic [11:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  adc_sample_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .sclk(sclk), .cs_n(cs_n), .miso(miso)
  );

  // behavioural ADC slave
  logic [11:0] s_word = 12'h000;
  logic hostile = 1'b0;
  int s_idx = 11;
  always @(negedge cs_n) s_idx = 11;
  always @(negedge sclk) if (s_idx > 0) s_idx = s_idx - 1;
  assign miso = (hostile && !sclk) ? ~s_word[s_idx] : s_word[s_idx];

  // monitor, sampled on the falling clock edge
  int hi_run = 0, wait_run = 0, m_acq = 0, m_conv = 0, pulses = 0;
  int rises = 0, h_run = 0, l_run = 0, half_err = 0, hold_err = 0;
  bit waiting = 0, prev_cs = 0, prev_sclk = 0;
  logic [11:0] held = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (cs_n && !prev_cs) begin hi_run = 1; rises++; end
      else if (cs_n) hi_run++;
      if (prev_cs && !cs_n) begin
        m_acq = hi_run; wait_run = 1; waiting = 1; pulses = 0;
      end else if (waiting && !cs_n && !sclk) wait_run++;
      if (sclk && !prev_sclk) begin
        if (waiting) begin m_conv = wait_run; waiting = 0; end
        else if (l_run != HL) half_err++;
        pulses++; h_run = 1;
      end else if (sclk) h_run++;
      if (!sclk && prev_sclk) begin
        if (h_run != HH) half_err++;
        l_run = 1;
      end else if (!sclk) l_run++;
      if (!done && result !== held) hold_err++;
      if (done) held = result;
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_meas();
    rises = 0; half_err = 0; hold_err = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_read(input logic [11:0] exp, input string tag);
    chk(result == exp, {tag, " R5 R6 word"}, result, exp);
    chk(m_acq == ACQ, "R2 acquisition length", m_acq, ACQ);
    chk(m_conv == CONV, "R3 conversion wait", m_conv, CONV);
    chk(pulses == 12 && half_err == 0, "R4 pulse count/halves", pulses, 12);
    chk(busy == 1'b0, "R11 busy low at done", busy, 0);
  endtask

  // {hostile, word}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 12'hA5C}, {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b0, 12'h800},
    {1'b1, 12'h001}, {1'b1, 12'h555}, {1'b1, 12'hAAA}, {1'b0, 12'h3C3}
  };

  initial begin
    bit seen;
    logic [11:0] prev_res;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(cs_n == 0 && sclk == 0 && done == 0 && busy == 0 && result == 0,
        "R1 reset state", {cs_n, sclk, done, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      hostile = VEC[k][12];
      s_word  = VEC[k][11:0];
      clear_meas();
      pulse_start();
      chk(cs_n == 1 && busy == 1, "R2 R11 cs_n high after start", cs_n, 1);
      wait_done(seen);
      chk(seen, "R8 done seen", seen, 1);
      check_read(VEC[k][11:0], "vector");
      @(negedge clk);
      chk(done == 0, "R8 done one cycle", done, 0);
      repeat (5) @(negedge clk);
      chk(cs_n == 0 && sclk == 0, "R7 idle lines after read", {cs_n, sclk}, 0);
      chk(hold_err == 0, "R8 result changes only on done", hold_err, 0);
    end
    hostile = 1'b0;

    // R9 start during acquisition and during shifting is ignored
    s_word = 12'h6B1;
    clear_meas();
    pulse_start();
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!sclk) @(negedge clk);
    repeat (7) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(seen);
    check_read(12'h6B1, "R9");
    chk(rises == 1, "R9 cs_n raised once", rises, 1);

    // R10 start in the done cycle, back to back
    s_word = 12'h2E7;
    clear_meas();
    pulse_start();
    wait_done(seen);
    start = 1'b1;
    s_word = 12'h9D4;
    @(negedge clk); start = 1'b0;
    prev_res = result;
    chk(cs_n == 1 && busy == 1, "R10 new read accepted", cs_n, 1);
    chk(prev_res == 12'h2E7, "R10 first word held", prev_res, 12'h2E7);
    wait_done(seen);
    check_read(12'h9D4, "R10 chained");
    chk(rises == 2, "R10 two acquisitions", rises, 2);

    // R1 reset in the middle of shifting
    s_word = 12'hFFF;
    pulse_start();
    while (!sclk) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n == 0 && sclk == 0 && busy == 0 && result == 0,
        "R1 mid-read reset", {cs_n, sclk, busy}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 0 && sclk == 0, "R1 quiet after reset", done, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule